// File: doc/BRIEF.md
# Stored-Matrix 3x3 Convolution Engine

This engine keeps an N x N matrix of signed 16-bit samples in local storage and convolves it with a 3x3 kernel of signed 16-bit weights. It computes only the positions where the whole kernel window lies inside the matrix, which gives (N-2) x (N-2) signed 32-bit results. These results leave on a valid/ready stream in row-major order. Because the matrix stays resident, a host can run any number of kernels over it one after another without loading it again.

The host reaches everything through a single write port.
- Matrix samples and the weights of K kernel slots share one flat address space.
- Writing the last weight of a slot starts a complete pass over the stored matrix with that slot's kernel.
- P parallel multiply-accumulate lanes each build one output. A lane adds its nine products over nine cycles. The finished outputs of a group of P lanes are then drained in order.
- While a pass runs, the write port holds off all new writes.

Top module: `conv3x3_engine`

## Requirements
- R1: After reset, busy, done and res_valid are 0 and wr_ready is 1.
- R2: Write address map, with NN = N*N:
  - Matrix element (row i, column j) is written at address i*N+j.
  - Weight (r,c) of kernel slot k is written at address NN+9*k+3*r+c.
- R3: An accepted write to the weight (2,2) of slot k, at address NN+9*k+8, starts a pass that uses slot k. busy is 1 from the cycle after that write until the final result of the pass is accepted.
- R4: Each result (i,j) is the sum over r,c in 0..2 of weight(r,c)*matrix(i+r,j+c).
  - Both operands are signed two's complement.
  - The sum wraps modulo 2^32. For example, all weights and all samples at -32768 give 0x40000000.
- R5: A pass emits exactly (N-2)^2 results in row-major order: i from 0 to N-3, and within each row j from 0 to N-3. res_last is 1 only on the final result.
- R6: res_filt carries the slot number k of the kernel used in the current pass.
- R7: While busy is 1, wr_ready is 0. A write presented during a pass takes effect only after the pass ends, so the results of the running pass do not change.
- R8: While res_valid is 1 and res_ready is 0, res_valid stays 1 and res_data stays stable.
- R9: done is a one-cycle pulse in the cycle after the final result is accepted. busy is 0 in that same cycle.
- R10: A later pass with a different slot reuses the stored matrix without any matrix writes, and its results are correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Host write request |
| wr_ready | output | 1 | Write accepted this cycle when high with wr_valid |
| wr_addr | input | $clog2(N*N+9*K) | Flat write address (matrix, then kernel slots) |
| wr_data | input | DW | Sample or weight value, signed |
| busy | output | 1 | Pass pending or running |
| done | output | 1 | One-cycle pulse after a pass completes |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer accepts result |
| res_data | output | ACCW | Result value, signed, wrapping |
| res_last | output | 1 | Final result of the pass |
| res_filt | output | max(1,$clog2(K)) | Kernel slot used for this pass |

## Verification
The hardest case to reach is a kernel write that arrives in the middle of a pass. It must stall until the final result is accepted and then start a new pass at once. The bench forks such a write alongside a consumer that applies random backpressure. It then checks three things:
- the write is accepted only after the done pulse;
- the running pass still matches the old weights;
- the next pass matches the new weights.

The small configuration has 16 outputs and three lanes, so the final group has only one active lane. The bench covers it together with slot reuse, extreme operands that wrap, and several random matrices.

// File: rtl/conv_pkg.sv
package conv_pkg;
  localparam int TAPS = 9;
  typedef enum logic [1:0] {ST_IDLE, ST_CALC, ST_DRAIN} conv_state_t;
endpackage

// File: rtl/conv_store.sv
module conv_store #(
  parameter int N    = 6,
  parameter int K    = 2,
  parameter int P    = 3,
  parameter int DW   = 16,
  parameter int AW   = 6,
  parameter int MIW  = 6,
  parameter int SLW  = 1
) (
  input  logic                   clk,
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_addr,
  input  logic [DW-1:0]          wr_data,
  input  logic [P-1:0][MIW-1:0]  rd_idx,
  input  logic [SLW-1:0]         slot,
  input  logic [3:0]             tap,
  output logic [P-1:0][DW-1:0]   rd_mat,
  output logic [DW-1:0]          coef
);
  localparam int NN = N * N;
  localparam int NC = 9 * K;

  logic [DW-1:0] mat_q [NN];
  logic [DW-1:0] cf_q  [NC];

  // matrix and kernel storage, written by the host only
  always_ff @(posedge clk) begin
    if (wr_en && (int'(wr_addr) < NN)) begin
      mat_q[int'(wr_addr)] <= wr_data;
    end
    if (wr_en && (int'(wr_addr) >= NN) && (int'(wr_addr) < NN + NC)) begin
      cf_q[int'(wr_addr) - NN] <= wr_data;
    end
  end

  for (genvar l = 0; l < P; l++) begin : g_rd
    assign rd_mat[l] = mat_q[int'(rd_idx[l])];
  end

  assign coef = cf_q[int'(slot) * 9 + int'(tap)];
endmodule

// File: rtl/conv_mac_lane.sv
module conv_mac_lane #(
  parameter int DW   = 16,
  parameter int ACCW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            clear,
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   b,
  output logic [ACCW-1:0] acc
);
  logic signed [2*DW-1:0] prod;
  logic [ACCW-1:0]        acc_d;
  logic [ACCW-1:0]        acc_q;

  assign prod = $signed(a) * $signed(b);

  always_comb begin
    acc_d = acc_q;
    if (en) begin
      acc_d = (clear ? '0 : acc_q) + ACCW'(prod);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign acc = acc_q;
endmodule

// File: rtl/conv_ctrl.sv
module conv_ctrl
  import conv_pkg::*;
#(
  parameter int N   = 6,
  parameter int P   = 3,
  parameter int OIW = 5,
  parameter int LW  = 2,
  parameter int SLW = 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [SLW-1:0] start_slot,
  input  logic           res_ready,
  output logic           calc,
  output logic           clear,
  output logic [3:0]     tap,
  output logic [OIW-1:0] base,
  output logic [LW-1:0]  drn,
  output logic [SLW-1:0] slot,
  output logic           res_valid,
  output logic           res_last,
  output logic           done,
  output logic           busy
);
  localparam int OC = N - 2;
  localparam int M  = OC * OC;

  conv_state_t    st_q, st_d;
  logic [3:0]     tap_q, tap_d;
  logic [OIW-1:0] base_q, base_d;
  logic [LW-1:0]  drn_q, drn_d;
  logic [SLW-1:0] slot_q, slot_d;
  logic           done_d, done_q;
  logic           lastg, lastl, hs;
  int             remain, nact;

  always_comb begin
    remain = M - int'(base_q);
    nact   = (remain < P) ? remain : P;
    lastg  = (remain <= P);
    lastl  = (int'(drn_q) == nact - 1);
    hs     = (st_q == ST_DRAIN) && res_ready;
    st_d   = st_q;
    tap_d  = tap_q;
    base_d = base_q;
    drn_d  = drn_q;
    slot_d = slot_q;
    done_d = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start) begin
        st_d   = ST_CALC;
        tap_d  = '0;
        base_d = '0;
        slot_d = start_slot;
      end
      ST_CALC: begin
        tap_d = tap_q + 4'd1;
        if (tap_q == 4'(TAPS - 1)) begin
          st_d  = ST_DRAIN;
          drn_d = '0;
        end
      end
      ST_DRAIN: if (res_ready) begin
        if (lastl) begin
          if (lastg) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
          end else begin
            st_d   = ST_CALC;
            tap_d  = '0;
            base_d = base_q + OIW'(P);
          end
        end else begin
          drn_d = drn_q + LW'(1);
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      tap_q  <= '0;
      base_q <= '0;
      drn_q  <= '0;
      slot_q <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      tap_q  <= tap_d;
      base_q <= base_d;
      drn_q  <= drn_d;
      slot_q <= slot_d;
      done_q <= done_d;
    end
  end

  assign calc      = (st_q == ST_CALC);
  assign clear     = (tap_q == 4'd0);
  assign tap       = tap_q;
  assign base      = base_q;
  assign drn       = drn_q;
  assign slot      = slot_q;
  assign res_valid = (st_q == ST_DRAIN);
  assign res_last  = (st_q == ST_DRAIN) && lastg && lastl;
  assign done      = done_q;
  assign busy      = (st_q != ST_IDLE);

  // emitted-result counter used only by the checks below
  logic [OIW-1:0] cnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cnt_q <= '0;
    else if (start && st_q == ST_IDLE)   cnt_q <= '0;
    else if (hs)                         cnt_q <= cnt_q + OIW'(1);
  end

  p_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && res_last) |-> (int'(cnt_q) == M - 1));
  p_done_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && res_last) |=> done);
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_tap_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    calc |-> (tap_q < 4'(TAPS)));
endmodule

// File: rtl/conv3x3_engine.sv
module conv3x3_engine #(
  parameter int N    = 6,
  parameter int K    = 2,
  parameter int P    = 3,
  parameter int DW   = 16,
  parameter int ACCW = 32,
  localparam int AW  = $clog2(N * N + 9 * K),
  localparam int SLW = (K > 1) ? $clog2(K) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_valid,
  output logic            wr_ready,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  output logic            busy,
  output logic            done,
  output logic            res_valid,
  input  logic            res_ready,
  output logic [ACCW-1:0] res_data,
  output logic            res_last,
  output logic [SLW-1:0]  res_filt
);
  localparam int NN  = N * N;
  localparam int OC  = N - 2;
  localparam int M   = OC * OC;
  localparam int MIW = $clog2(NN);
  localparam int OIW = $clog2(M + P + 1);
  localparam int LW  = (P > 1) ? $clog2(P) : 1;

  // reset: asserted asynchronously, released on the clock
  logic rs1_q, rs2_q, rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_i = rs2_q;

  logic                  start, cbusy, calc, clear;
  logic [3:0]            tap;
  logic [OIW-1:0]        base;
  logic [LW-1:0]         drn;
  logic [SLW-1:0]        slot, pend_slot_q, pend_slot_d;
  logic                  pend_q, pend_d, wr_acc, trig;
  logic [P-1:0][MIW-1:0] rd_idx;
  logic [P-1:0][DW-1:0]  rd_mat;
  logic [DW-1:0]         coef;
  logic [ACCW-1:0]       acc [P];
  int                    fo;

  assign wr_acc = wr_valid && wr_ready;

  always_comb begin
    fo          = int'(wr_addr) - NN;
    trig        = wr_acc && (fo >= 0) && (fo < 9 * K) && ((fo % 9) == 8);
    pend_d      = pend_q;
    pend_slot_d = pend_slot_q;
    if (trig) begin
      pend_d      = 1'b1;
      pend_slot_d = SLW'(fo / 9);
    end else if (start) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      pend_q      <= 1'b0;
      pend_slot_q <= '0;
    end else begin
      pend_q      <= pend_d;
      pend_slot_q <= pend_slot_d;
    end
  end

  assign start    = pend_q && !cbusy;
  assign busy     = pend_q || cbusy;
  assign wr_ready = !busy;

  conv_store #(.N(N), .K(K), .P(P), .DW(DW), .AW(AW), .MIW(MIW), .SLW(SLW)) u_store (
    .clk(clk), .wr_en(wr_acc), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_idx(rd_idx), .slot(slot), .tap(tap), .rd_mat(rd_mat), .coef(coef)
  );

  conv_ctrl #(.N(N), .P(P), .OIW(OIW), .LW(LW), .SLW(SLW)) u_ctrl (
    .clk(clk), .rst_n(rst_i), .start(start), .start_slot(pend_slot_q),
    .res_ready(res_ready), .calc(calc), .clear(clear), .tap(tap),
    .base(base), .drn(drn), .slot(slot), .res_valid(res_valid),
    .res_last(res_last), .done(done), .busy(cbusy)
  );

  for (genvar l = 0; l < P; l++) begin : g_lane
    always_comb begin
      int pos, row, col;
      pos = int'(base) + l;
      row = pos / OC;
      col = pos % OC;
      if (pos < M) rd_idx[l] = MIW'((row + int'(tap) / 3) * N + col + int'(tap) % 3);
      else         rd_idx[l] = '0;
    end

    conv_mac_lane #(.DW(DW), .ACCW(ACCW)) u_lane (
      .clk(clk), .rst_n(rst_i), .en(calc), .clear(clear),
      .a(rd_mat[l]), .b(coef), .acc(acc[l])
    );
  end

  assign res_data = acc[drn];
  assign res_filt = slot;

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_i)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && $stable(res_last)));
  p_busy_end_r3: assert property (@(posedge clk) disable iff (!rst_i)
    $fell(busy) |-> done);
  p_no_write_in_pass_r7: assert property (@(posedge clk) disable iff (!rst_i)
    res_valid |-> !wr_ready);
endmodule

// File: tb/tb_conv3x3_engine.sv
module tb_conv3x3_engine;
  localparam int N  = 6;
  localparam int K  = 2;
  localparam int P  = 3;
  localparam int NN = N * N;
  localparam int OC = N - 2;
  localparam int M  = OC * OC;
  localparam int AW = $clog2(NN + 9 * K);

  logic clk, rst_n, wr_valid, wr_ready, busy, done, res_valid, res_ready, res_last;
  logic [AW-1:0] wr_addr;
  logic [15:0] wr_data;
  logic [31:0] res_data;
  logic [0:0]  res_filt;

  conv3x3_engine #(.N(N), .K(K), .P(P), .DW(16), .ACCW(32)) dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy), .done(done),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .res_last(res_last), .res_filt(res_filt)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int errs = 0, checks = 0, cyc = 0, done_cyc = 0, acc_cyc = 0;
  int unsigned seed = 32'h1234_5678;
  logic [15:0] mat_m [NN];
  logic [15:0] cf_m  [9*K];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int unsigned rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  function automatic logic [31:0] expect_at(int k, int i, int j);
    logic signed [31:0] s = 0;
    for (int r = 0; r < 3; r++)
      for (int c = 0; c < 3; c++)
        s += $signed(cf_m[9*k+3*r+c]) * $signed(mat_m[(i+r)*N + j + c]);
    return s;
  endfunction

  // R2: writes use the flat map (matrix at i*N+j, slot k weight r,c at NN+9k+3r+c)
  task automatic wr(input int a, input logic [15:0] d);
    wr_valid = 1'b1;
    wr_addr  = AW'(a);
    wr_data  = d;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic load_mat();
    for (int a = 0; a < NN; a++) wr(a, mat_m[a]);
  endtask

  task automatic load_filt(input int k);
    for (int t = 0; t < 9; t++) wr(NN + 9*k + t, cf_m[9*k+t]);
  endtask

  // consume one pass; mode 0 = always ready, 1 = random backpressure
  task automatic collect(input int k, input int mode);
    logic [31:0] ev [M];
    logic [31:0] held = 0;
    bit hv = 0, rdy;
    int n = 0, guard = 0;
    for (int o = 0; o < M; o++) ev[o] = expect_at(k, o / OC, o % OC);
    @(negedge clk);
    chk(busy === 1'b1, "R3 busy after trigger", 32'(busy), 1);
    while (n < M && guard < 5000) begin
      guard++;
      rdy = (mode == 0) ? 1'b1 : rnd() >> 31;
      res_ready = rdy;
      if (hv) begin
        chk(res_valid === 1'b1 && res_data === held, "R8 hold under backpressure", res_data, held);
        hv = 0;
      end
      if (res_valid) begin
        if (rdy) begin
          chk(res_data === ev[n], "R4/R10 value", res_data, ev[n]);
          chk(res_last === (n == M - 1), "R5 last flag", 32'(res_last), 32'(n == M - 1));
          chk(int'(res_filt) == k, "R6 slot tag", 32'(res_filt), 32'(k));
          n++;
        end else begin
          held = res_data;
          hv   = 1;
        end
      end
      @(negedge clk);
    end
    res_ready = 1'b0;
    chk(n == M, "R5 result count", 32'(n), 32'(M));
    chk(done === 1'b1 && busy === 1'b0, "R9 done pulse, busy low", {30'd0, done, busy}, 32'h2);
    done_cyc = cyc;
    @(negedge clk);
    chk(done === 1'b0, "R9 done single cycle", 32'(done), 0);
  endtask

  initial begin
    rst_n = 1'b0; wr_valid = 1'b0; wr_addr = '0; wr_data = '0; res_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && res_valid === 1'b0, "R1 reset outputs",
        {29'd0, busy, done, res_valid}, 0);
    chk(wr_ready === 1'b1, "R1 wr_ready", 32'(wr_ready), 1);

    // R2 R3 R4: ramp matrix, slot 0 small kernel, free-flowing consumer
    for (int a = 0; a < NN; a++) mat_m[a] = 16'(a * 3 - 20);
    for (int t = 0; t < 9; t++) cf_m[t] = 16'(t - 4);
    for (int t = 0; t < 9; t++) cf_m[9+t] = 16'(t * t + 1);
    load_mat();
    load_filt(0);
    collect(0, 0);

    // R10 R6: second slot, no matrix reload, random backpressure
    load_filt(1);
    collect(1, 1);

    // R3: rewriting only weight (2,2) of slot 0 restarts a pass
    cf_m[8] = 16'h7fff;
    wr(NN + 8, cf_m[8]);
    collect(0, 1);

    // R7: write during a pass is held until the pass completes
    cf_m[17] = 16'h8001;
    wr(NN + 17, cf_m[17]);
    fork
      collect(1, 1);
      begin
        wr(NN + 8, 16'h0003);
        acc_cyc = cyc;
        cf_m[8] = 16'h0003;
      end
    join
    chk(acc_cyc > done_cyc, "R7 write held until pass end", 32'(acc_cyc), 32'(done_cyc + 1));
    collect(0, 0);

    // R4: extreme operands wrap, -32768 everywhere gives 0x40000000
    for (int a = 0; a < NN; a++) mat_m[a] = 16'h8000;
    for (int t = 0; t < 9; t++) cf_m[9+t] = 16'h8000;
    load_mat();
    load_filt(1);
    chk(expect_at(1, 0, 0) == 32'h4000_0000, "R4 bench model wrap", expect_at(1, 0, 0), 32'h4000_0000);
    collect(1, 0);
    for (int a = 0; a < NN; a++) mat_m[a] = 16'h7fff;
    for (int t = 0; t < 9; t++) cf_m[t] = 16'h7fff;
    load_mat();
    load_filt(0);
    collect(0, 1);

    // random sweep over matrices and both slots
    for (int rep = 0; rep < 6; rep++) begin
      for (int a = 0; a < NN; a++) mat_m[a] = 16'(rnd() >> 16);
      for (int t = 0; t < 9*K; t++) cf_m[t] = 16'(rnd() >> 16);
      load_mat();
      load_filt(rep % K);
      collect(rep % K, rep % 2);
      load_filt((rep + 1) % K);
      collect((rep + 1) % K, 1);
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule